// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one memory request from a whole warp and turns it into the fewest aligned memory transactions that serve it. A request carries one 32-bit byte address for each lane, each lane touching a 4-byte word, and an active-lane mask. The coalescer groups the active lanes by the aligned segment their address falls in. It then issues one transaction per distinct segment, one per cycle, on a valid/ready channel. Each transaction carries the segment base address and a mask of the lanes it serves.

The segment size can be 32, 64 or 128 bytes. It is chosen with the request and held until that request is finished. Contiguous word accesses therefore collapse into a single transaction. Strided accesses spread over more segments as the stride grows, and fully scattered lanes cost one transaction each. When the last transaction has been taken, the block pulses a completion flag together with the number of transactions it issued. After that it is ready for the next request.

Top module: `warp_coalescer`

## Requirements
- R1: After reset the block is idle: `req_ready_o` is 1, `txn_valid_o` is 0 and `done_o` is 0.
- R2: `seg_sel_i` is sampled when a request is accepted. Value 0 selects 32-byte segments, 1 selects 64-byte segments, and 2 or 3 select 128-byte segments.
- R3: Each transaction's `txn_base_o` is the address of its lowest served lane with the low log2(segment size) bits cleared. `txn_lanes_o` bit i is set exactly for the active, still unserved lanes i whose address lies in that segment.
- R4: Thirty-two active lanes at a 128-byte-aligned base + 4·i with 128-byte segments produce exactly one transaction, whose lane mask is all ones.
- R5: With all lanes active at an aligned base + s·i (s a power of two), the transaction count is 32·s/S when s < S, and 32 when s ≥ S, for segment size S. A zero stride gives 1.
- R6: If every active lane lies in a different segment, there is one transaction per active lane, up to 32.
- R7: Lanes whose mask bit is 0 appear in no transaction. A request with an all-zero mask issues no transaction and completes with a count of 0.
- R8: Transactions are issued in ascending order of the lowest-numbered lane not yet served, whatever the address order.
- R9: While a request is in progress `req_ready_o` is 0. A request presented then is not taken and does not change the transactions being issued.
- R10: While `txn_valid_o` is 1 and `txn_ready_i` is 0, the valid, base and lane mask stay unchanged into the next cycle.
- R11: `done_o` is 1 for exactly the one cycle after the final transaction handshake (or the cycle after acceptance for an empty request). In that cycle `done_count_o` equals the number of transactions issued for the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_sel_i | input | 2 | Segment size select, sampled with the request |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle and able to take a request |
| req_mask_i | input | LANES | Active-lane mask |
| req_addr_i | input | LANES*ADDR_W | Lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| txn_valid_o | output | 1 | Transaction present |
| txn_ready_i | input | 1 | Downstream takes the transaction |
| txn_base_o | output | ADDR_W | Aligned segment base address |
| txn_lanes_o | output | LANES | Lanes served by this transaction |
| done_o | output | 1 | Request finished (one-cycle pulse) |
| done_count_o | output | CNT_W | Transactions issued for the finished request |

## Verification
The assertions assume the downstream only sees a transaction as taken when valid and ready are high together. They also assume requests are presented only through the valid/ready handshake, so nothing is held across a busy period except what was latched at acceptance. The stimulus drives every input on the falling edge. It presents a request once `req_ready_o` is seen high and drops it right after acceptance, except in deliberate runs that leave a different request on the port while the block is busy. Backpressure comes from either a constant-high ready or a pseudo-random ready pattern. Expected transactions come from a division-based segment model over many stride, mask and segment-size combinations.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic [1:0] {
    SEG_32B  = 2'd0,
    SEG_64B  = 2'd1,
    SEG_128B = 2'd2,
    SEG_128X = 2'd3
  } seg_sel_e;

  // number of byte-offset bits inside one segment
  function automatic int unsigned seg_shift(input logic [1:0] sel);
    case (sel)
      SEG_32B: seg_shift = 5;
      SEG_64B: seg_shift = 6;
      default: seg_shift = 7;
    endcase
  endfunction
endpackage

// File: rtl/coal_lane_match.sv
module coal_lane_match #(
  parameter int unsigned LANES  = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LANE_W = $clog2(LANES)
) (
  input  logic [LANES*ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]        pending_i,
  input  logic [1:0]              seg_sel_i,
  output logic                    any_o,
  output logic [ADDR_W-1:0]       base_o,
  output logic [ADDR_W-1:0]       seg_mask_o,
  output logic [LANES-1:0]        hit_o
);
  import coal_pkg::*;

  logic [ADDR_W-1:0] lane_seg [LANES];
  logic [LANE_W-1:0] first_lane;

  assign seg_mask_o = {ADDR_W{1'b1}} << seg_shift(seg_sel_i);
  assign any_o      = |pending_i;

  // lowest pending lane leads the next transaction
  always_comb begin
    first_lane = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pending_i[i]) first_lane = LANE_W'(i);
    end
  end

  assign base_o = lane_seg[first_lane];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_seg[g] = addr_i[g*ADDR_W +: ADDR_W] & seg_mask_o;
    assign hit_o[g]    = pending_i[g] && (lane_seg[g] == base_o);
  end
endmodule

// File: rtl/coal_req_store.sv
module coal_req_store #(
  parameter int unsigned LANES  = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = $clog2(LANES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    accept_i,
  input  logic [LANES*ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]        mask_i,
  input  logic [1:0]              sel_i,
  input  logic                    fire_i,
  input  logic [LANES-1:0]        hit_i,
  output logic                    busy_o,
  output logic [LANES-1:0]        pending_o,
  output logic [LANES*ADDR_W-1:0] addr_o,
  output logic [1:0]              sel_o,
  output logic [CNT_W-1:0]        count_o
);
  logic finish;
  assign finish = busy_o && (pending_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o    <= 1'b0;
      pending_o <= '0;
      addr_o    <= '0;
      sel_o     <= 2'd0;
      count_o   <= '0;
    end else if (accept_i) begin
      busy_o    <= 1'b1;
      pending_o <= mask_i;
      addr_o    <= addr_i;
      sel_o     <= sel_i;
      count_o   <= '0;
    end else if (busy_o) begin
      if (fire_i) begin
        pending_o <= pending_o & ~hit_i;
        count_o   <= count_o + CNT_W'(1);
      end
      if (finish) busy_o <= 1'b0;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(LANES)); // R6
  AST_NO_LANE_REVIVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (pending_o & ~$past(pending_o)) == '0); // R9
  AST_IDLE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> pending_o == '0); // R7
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !accept_i); // R9
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int unsigned LANES  = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = $clog2(LANES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              seg_sel_i,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [LANES-1:0]        req_mask_i,
  input  logic [LANES*ADDR_W-1:0] req_addr_i,
  output logic                    txn_valid_o,
  input  logic                    txn_ready_i,
  output logic [ADDR_W-1:0]       txn_base_o,
  output logic [LANES-1:0]        txn_lanes_o,
  output logic                    done_o,
  output logic [CNT_W-1:0]        done_count_o
);
  localparam int unsigned LANE_W = $clog2(LANES);

  logic                    busy;
  logic [LANES-1:0]        pending;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [1:0]              sel_q;
  logic                    any_pending;
  logic [ADDR_W-1:0]       seg_mask;
  logic                    accept, fire;

  assign req_ready_o  = !busy;
  assign accept       = req_valid_i && !busy;
  assign txn_valid_o  = busy && any_pending;
  assign fire         = txn_valid_o && txn_ready_i;
  assign done_o       = busy && !any_pending;

  coal_req_store #(.LANES(LANES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .addr_i   (req_addr_i),
    .mask_i   (req_mask_i),
    .sel_i    (seg_sel_i),
    .fire_i   (fire),
    .hit_i    (txn_lanes_o),
    .busy_o   (busy),
    .pending_o(pending),
    .addr_o   (addr_q),
    .sel_o    (sel_q),
    .count_o  (done_count_o)
  );

  coal_lane_match #(.LANES(LANES), .ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_match (
    .addr_i    (addr_q),
    .pending_i (pending),
    .seg_sel_i (sel_q),
    .any_o     (any_pending),
    .base_o    (txn_base_o),
    .seg_mask_o(seg_mask),
    .hit_o     (txn_lanes_o)
  );

  AST_TXN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && !txn_ready_i |=> txn_valid_o && $stable(txn_base_o) && $stable(txn_lanes_o)); // R10
  AST_BASE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> (txn_base_o & ~seg_mask) == '0); // R3
  AST_LANES_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> txn_lanes_o != '0 && (txn_lanes_o & ~pending) == '0); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_READY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> !req_ready_o); // R9
endmodule

// File: tb/warp_coalescer_test.sv
module warp_coalescer_test;
  localparam int LANES = 32;
  localparam int AW    = 32;
  localparam int CW    = $clog2(LANES + 1);

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [1:0]        seg_sel_i = 2'd0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [LANES-1:0]  req_mask_i = '0;
  logic [LANES*AW-1:0] req_addr_i = '0;
  logic              txn_valid_o;
  logic              txn_ready_i = 1'b0;
  logic [AW-1:0]     txn_base_o;
  logic [LANES-1:0]  txn_lanes_o;
  logic              done_o;
  logic [CW-1:0]     done_count_o;

  always #5 clk = ~clk;

  warp_coalescer #(.LANES(LANES), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .seg_sel_i(seg_sel_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_mask_i(req_mask_i), .req_addr_i(req_addr_i),
    .txn_valid_o(txn_valid_o), .txn_ready_i(txn_ready_i),
    .txn_base_o(txn_base_o), .txn_lanes_o(txn_lanes_o),
    .done_o(done_o), .done_count_o(done_count_o)
  );

  int errors = 0;
  int checks = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;
  logic [AW-1:0]    a [LANES];
  logic [AW-1:0]    exp_base [LANES];
  logic [LANES-1:0] exp_lanes [LANES];
  int exp_n;

  function automatic logic [31:0] step(input logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // reference: group by segment index computed with division
  task automatic model(input logic [LANES-1:0] mask, input logic [1:0] sel);
    logic [LANES-1:0] pend;
    longint size;
    size = (sel == 2'd0) ? 32 : (sel == 2'd1) ? 64 : 128;
    pend = mask;
    exp_n = 0;
    while (pend != '0) begin
      int j;
      longint seg;
      logic [LANES-1:0] l;
      j = 0;
      for (int i = LANES - 1; i >= 0; i--) if (pend[i]) j = i;
      seg = longint'(a[j]) / size;
      l = '0;
      for (int i = 0; i < LANES; i++)
        if (pend[i] && (longint'(a[i]) / size == seg)) l[i] = 1'b1;
      exp_base[exp_n]  = AW'(seg * size);
      exp_lanes[exp_n] = l;
      pend = pend & ~l;
      exp_n++;
    end
  endtask

  // rmode: 0 always ready, 1 pseudo-random; spam: keep a bogus request on the port
  task automatic run(input logic [LANES-1:0] mask, input logic [1:0] sel,
                     input int rmode, input bit spam);
    int k;
    model(mask, sel);
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    for (int i = 0; i < LANES; i++) req_addr_i[i*AW +: AW] = a[i];
    req_mask_i  = mask;
    seg_sel_i   = sel;
    req_valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (spam) begin
      req_mask_i = '1;
      seg_sel_i  = ~sel;
      for (int i = 0; i < LANES; i++) req_addr_i[i*AW +: AW] = 32'hF000_0000 + AW'(i * 4096);
    end else begin
      req_valid_i = 1'b0;
    end
    k = 0;
    forever begin
      if (k == exp_n) begin
        chk(done_o == 1'b1, "R11", "done pulse", 64'(done_o), 64'd1);
        chk(done_count_o == CW'(exp_n), "R11", "done count", 64'(done_count_o), 64'(exp_n));
        chk(txn_valid_o == 1'b0, "R7", "no txn at done", 64'(txn_valid_o), 64'd0);
        req_valid_i = 1'b0;
        txn_ready_i = 1'b0;
        break;
      end
      lfsr = step(lfsr);
      txn_ready_i = (rmode == 0) ? 1'b1 : lfsr[3];
      #1;
      chk(done_o == 1'b0, "R11", "early done", 64'(done_o), 64'd0);
      chk(req_ready_o == 1'b0, "R9", "ready while busy", 64'(req_ready_o), 64'd0);
      chk(txn_valid_o == 1'b1, "R10", "txn valid", 64'(txn_valid_o), 64'd1);
      chk(txn_base_o == exp_base[k], "R3", "base", 64'(txn_base_o), 64'(exp_base[k]));
      chk(txn_lanes_o == exp_lanes[k], "R8", "lane order/mask", 64'(txn_lanes_o), 64'(exp_lanes[k]));
      if (txn_ready_i) k++;
      @(negedge clk);
    end
  endtask

  task automatic fill_stride(input logic [AW-1:0] base, input int s);
    for (int i = 0; i < LANES; i++) a[i] = base + AW'(i * s);
  endtask

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready_o == 1'b1, "R1", "reset ready", 64'(req_ready_o), 64'd1);
    chk(txn_valid_o == 1'b0, "R1", "reset valid", 64'(txn_valid_o), 64'd0);
    chk(done_o == 1'b0, "R1", "reset done", 64'(done_o), 64'd0);
    rst_ni = 1'b1;

    // R4: contiguous words, 128-byte segments
    fill_stride(32'h0001_0000, 4);
    run('1, 2'd2, 0, 1'b0);
    chk(exp_n == 1 && exp_lanes[0] == '1, "R4", "single txn model", 64'(exp_n), 64'd1);

    // R5 and R2: stride sweep over all segment selects
    for (int sel = 0; sel < 4; sel++) begin
      for (int e = 0; e < 8; e++) begin
        int s, S, want;
        s = (e == 0) ? 0 : (2 << e);
        S = (sel == 0) ? 32 : (sel == 1) ? 64 : 128;
        want = (s == 0) ? 1 : (s >= S) ? 32 : (32 * s) / S;
        fill_stride(32'h0002_0000, s);
        run('1, 2'(sel), e % 2, e == 3);
        chk(exp_n == want, "R5", "stride count formula", 64'(exp_n), 64'(want));
        // partial masks exercise R7
        run(32'h5555_5555, 2'(sel), 1, 1'b0);
        run(32'h8000_0001, 2'(sel), 0, 1'b0);
        run('0, 2'(sel), 0, 1'b0);
        fill_stride(32'h0002_0044, s);
        lfsr = step(lfsr);
        run(lfsr, 2'(sel), 1, 1'b0);
      end
    end

    // R6: every lane in its own segment
    fill_stride(32'h0003_0000, 128);
    run('1, 2'd2, 1, 1'b0);
    chk(exp_n == 32, "R6", "worst case count", 64'(exp_n), 64'd32);
    fill_stride(32'h0003_0000, 32);
    run('1, 2'd0, 0, 1'b1);

    // R8: addresses descending with lane number
    for (int i = 0; i < LANES; i++) a[i] = 32'h0004_0000 + AW'((LANES - 1 - i) * 256);
    run('1, 2'd1, 1, 1'b0);

    // mixed clustered addresses
    for (int r = 0; r < 40; r++) begin
      for (int i = 0; i < LANES; i++) begin
        lfsr = step(lfsr);
        a[i] = 32'h0005_0000 + (lfsr & 32'h0000_03FC);
      end
      lfsr = step(lfsr);
      run(lfsr | 32'h0000_0100, 2'(r % 4), r % 2, r % 5 == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule